// File: doc/BRIEF.md
# Write-Once Pin Routing Options Register

This block holds one 8-bit system options register that sits on a simple register bus. Software writes it once after reset to choose where the serial port, SPI, I2C and timer-2 signals leave the chip, and whether two shared pins act as the debug pin and the reset pin. The first bus write to the register locks all eight bits. Further writes have no effect until the next reset.

Two reset inputs are present. Power-on reset restores every bit. Warm reset also restores every bit and clears the lock, except the reset-pin enable, which keeps its value. The block decodes the register address and serves reads. From the stored bits it drives one select output per peripheral and one pin-ownership mask per port (A, B, C, D, E and H) for the port multiplexer. The wake and stop bits are only stored and brought out.

Top module: `sys_pin_opts`

## Requirements
- R1: On power-on reset the register takes the value 0x0C. The debug-pin enable (bit 3) and the reset-pin enable (bit 2) are set and all other bits are clear. The lock is cleared.
- R2: A write to address 0x3004 while unlocked stores all eight data bits and sets the lock, whatever the data. Bit order from 7 down to 0 is: serial-0 alternate, SPI-0 alternate, I2C alternate, timer-2 alternate, debug-pin enable, reset-pin enable, wake, stop.
- R3: While locked, writes to 0x3004 leave the register unchanged until the next reset of either kind.
- R4: Warm reset keeps bit 2, sets bit 3, clears every other bit and clears the lock, so the register can be written again.
- R5: When power-on and warm reset are asserted together, the power-on result (0x0C, unlocked) applies.
- R6: Writes to any other address change neither the register nor the lock. Reads from any other address return 0.
- R7: A read of 0x3004 returns the current register value combinationally in the same cycle and never sets the lock.
- R8: Serial-0 routing: with bit 7 = 0 it owns port B pins 0 and 1; with bit 7 = 1 it owns port A pins 2 and 3.
- R9: I2C routing: with bit 5 = 0 it owns port A pins 3 and 2; with bit 5 = 1 it owns port B pins 7 and 6.
- R10: SPI-0 routing: with bit 6 = 0 it owns port B pins 2 to 5; with bit 6 = 1 it owns port E pins 0 to 3.
- R11: Timer-2 routing: with bit 4 = 0 it owns port C pins 0 to 3; with bit 4 = 1 it owns port H pins 0 and 1 and port D pins 0 and 1. Port B pins 4 and 5 are owned in both settings.
- R12: Bit 3 drives the debug-pin enable and claims port A pin 4. Bit 2 drives the reset-pin enable, claims port A pin 5 and drives the pull-up enable. Bits 7 to 0 each drive their own select output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not selected |
| uart0_alt | output | 1 | Serial-0 alternate pin select |
| spi0_alt | output | 1 | SPI-0 alternate pin select |
| i2c_alt | output | 1 | I2C alternate pin select |
| tmr2_alt | output | 1 | Timer-2 alternate pin select |
| dbg_pin_en | output | 1 | Shared pin acts as debug pin |
| rst_pin_en | output | 1 | Shared pin acts as reset input |
| rst_pullup_en | output | 1 | Internal pull-up on reset pin |
| wake_opt | output | 1 | Stored wake bit |
| stop_opt | output | 1 | Stored stop-enable bit |
| porta_owned | output | 8 | Port A pins claimed by routed functions |
| portb_owned | output | 8 | Port B pins claimed by routed functions |
| portc_owned | output | 8 | Port C pins claimed by routed functions |
| portd_owned | output | 8 | Port D pins claimed by routed functions |
| porte_owned | output | 8 | Port E pins claimed by routed functions |
| porth_owned | output | 8 | Port H pins claimed by routed functions |

## Verification
The select outputs and the six ownership masks are combinational decodes of the stored byte. A wrong stored bit therefore shows on a port one clock edge after the cause and stays visible until the next reset. A wrong lock state stays hidden until the next write to the register: that write either changes a value it should not or fails to land, and the change shows on the following cycle. A reference model in the bench follows both resets and the lock, and it is compared against every output on every cycle. Corruption of the reset-pin bit across a warm reset shows immediately on the pull-up output.

// File: rtl/sys_pin_opts.sv
module sys_pin_opts #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h3000,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 16'h0004
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              warm_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              uart0_alt,
  output logic              spi0_alt,
  output logic              i2c_alt,
  output logic              tmr2_alt,
  output logic              dbg_pin_en,
  output logic              rst_pin_en,
  output logic              rst_pullup_en,
  output logic              wake_opt,
  output logic              stop_opt,
  output logic [7:0]        porta_owned,
  output logic [7:0]        portb_owned,
  output logic [7:0]        portc_owned,
  output logic [7:0]        portd_owned,
  output logic [7:0]        porte_owned,
  output logic [7:0]        porth_owned
);

  localparam logic [ADDR_W-1:0] REG_ADDR = BASE_ADDR + REG_OFFSET;
  localparam logic [7:0] RESET_VAL = 8'h0C;
  localparam logic [7:0] WARM_KEEP = 8'h04;

  logic [7:0] opt_q;
  logic       locked_q;
  logic       hit, wr_hit;

  assign hit    = (bus_addr == REG_ADDR);
  assign wr_hit = bus_wr && hit;

  always_ff @(posedge clk) begin
    if (por_rst) begin
      opt_q    <= RESET_VAL;
      locked_q <= 1'b0;
    end else if (warm_rst) begin
      opt_q    <= (RESET_VAL & ~WARM_KEEP) | (opt_q & WARM_KEEP);
      locked_q <= 1'b0;
    end else if (wr_hit && !locked_q) begin
      opt_q    <= bus_wdata;
      locked_q <= 1'b1;
    end
  end

  assign bus_rdata = (bus_rd && hit) ? opt_q : 8'h00;

  assign uart0_alt     = opt_q[7];
  assign spi0_alt      = opt_q[6];
  assign i2c_alt       = opt_q[5];
  assign tmr2_alt      = opt_q[4];
  assign dbg_pin_en    = opt_q[3];
  assign rst_pin_en    = opt_q[2];
  assign rst_pullup_en = opt_q[2];
  assign wake_opt      = opt_q[1];
  assign stop_opt      = opt_q[0];

  assign porta_owned = {2'b00, opt_q[2], opt_q[3], {2{opt_q[7] | ~opt_q[5]}}, 2'b00};
  assign portb_owned = {{2{opt_q[5]}}, 2'b11, {2{~opt_q[6]}}, {2{~opt_q[7]}}};
  assign portc_owned = {4'b0000, {4{~opt_q[4]}}};
  assign portd_owned = {6'b000000, {2{opt_q[4]}}};
  assign porte_owned = {4'b0000, {4{opt_q[6]}}};
  assign porth_owned = {6'b000000, {2{opt_q[4]}}};

  p_lock_takes_r2: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
    (wr_hit && !locked_q) |=> (locked_q && opt_q == $past(bus_wdata)));

  p_locked_hold_r3: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
    locked_q |=> ($stable(opt_q) && locked_q));

  p_warm_keep_r4: assert property (@(posedge clk) disable iff (por_rst)
    warm_rst |=> (opt_q[2] == $past(opt_q[2]) && opt_q[3] && !locked_q));

  p_foreign_write_r6: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
    (bus_wr && !hit) |=> ($stable(opt_q) && locked_q == $past(locked_q)));

  p_read_nolock_r7: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
    (bus_rd && !bus_wr && !locked_q) |=> !locked_q);

endmodule

// File: tb/tb_sys_pin_opts.sv
module tb_sys_pin_opts;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic por_rst = 1'b1, warm_rst = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic uart0_alt, spi0_alt, i2c_alt, tmr2_alt, dbg_pin_en, rst_pin_en, rst_pullup_en, wake_opt, stop_opt;
  logic [7:0] pa, pb, pc, pd, pe, ph;

  sys_pin_opts dut (
    .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .uart0_alt(uart0_alt), .spi0_alt(spi0_alt), .i2c_alt(i2c_alt), .tmr2_alt(tmr2_alt),
    .dbg_pin_en(dbg_pin_en), .rst_pin_en(rst_pin_en), .rst_pullup_en(rst_pullup_en),
    .wake_opt(wake_opt), .stop_opt(stop_opt),
    .porta_owned(pa), .portb_owned(pb), .portc_owned(pc),
    .portd_owned(pd), .porte_owned(pe), .porth_owned(ph)
  );

  int checks = 0, failures = 0;
  int mval = 'h0C;
  bit mlock = 1'b0;
  bit done = 1'b0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit b(int v, int i);
    return ((v >> i) & 1) != 0;
  endfunction

  task automatic compare_all();
    int ea = 0, eb = 0, ec = 0, ed = 0, ee = 0, eh = 0, er;
    if (b(mval, 7)) ea = ea | 'h0C; else eb = eb | 'h03;
    if (b(mval, 5)) eb = eb | 'hC0; else ea = ea | 'h0C;
    if (b(mval, 6)) ee = ee | 'h0F; else eb = eb | 'h3C;
    if (b(mval, 4)) begin ed = ed | 'h03; eh = eh | 'h03; end else ec = ec | 'h0F;
    eb = eb | 'h30;
    if (b(mval, 3)) ea = ea | 'h10;
    if (b(mval, 2)) ea = ea | 'h20;
    er = (bus_rd && bus_addr == 16'h3004) ? mval : 0;
    chk("R7/R6 rdata", int'(bus_rdata), er);
    chk("R8 portA/B serial", int'(pa), ea);
    chk("R9/R10 portB", int'(pb), eb);
    chk("R11 portC", int'(pc), ec);
    chk("R11 portD", int'(pd), ed);
    chk("R10 portE", int'(pe), ee);
    chk("R11 portH", int'(ph), eh);
    chk("R12 selects", int'({uart0_alt, spi0_alt, i2c_alt, tmr2_alt, dbg_pin_en, rst_pin_en, wake_opt, stop_opt}), mval);
    chk("R12 pullup", int'(rst_pullup_en), int'(b(mval, 2)));
  endtask

  task automatic step(bit p, bit w, logic [15:0] a, bit wr, bit rd, logic [7:0] d);
    @(negedge clk);
    por_rst = p; warm_rst = w; bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d;
    #1;
    compare_all();
    @(posedge clk);
    if (p) begin mval = 'h0C; mlock = 1'b0; end
    else if (w) begin mval = 'h08 | (mval & 'h04); mlock = 1'b0; end
    else if (wr && a == 16'h3004 && !mlock) begin mval = int'(d); mlock = 1'b1; end
  endtask

  task automatic rd_reg(string req, int exp);
    step(0, 0, 16'h3004, 0, 1, 8'h00);
    chk(req, mval, exp);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(1, 0, 16'h0, 0, 0, 8'h00);
    step(1, 0, 16'h0, 0, 0, 8'h00);
    rd_reg("R1 reset value", 'h0C);
    step(0, 0, 16'h3000, 0, 1, 8'h00);           // R6 foreign read returns 0
    step(0, 0, 16'h3005, 1, 0, 8'hFF);           // R6 foreign write ignored
    rd_reg("R6 foreign write", 'h0C);
    step(0, 0, 16'h3004, 0, 1, 8'h00);           // R7 read does not lock
    step(0, 0, 16'h3004, 1, 0, 8'hF3);           // R2 first write
    rd_reg("R2 stored", 'hF3);
    step(0, 0, 16'h3004, 1, 0, 8'h00);           // R3 locked
    step(0, 0, 16'h3004, 1, 0, 8'h5A);
    rd_reg("R3 locked", 'hF3);
    step(0, 1, 16'h0, 0, 0, 8'h00);              // R4 warm, bit2 was 0
    rd_reg("R4 warm keep 0", 'h08);
    step(0, 0, 16'h3004, 1, 0, 8'h04);
    step(0, 1, 16'h0, 0, 0, 8'h00);              // R4 warm, bit2 was 1
    rd_reg("R4 warm keep 1", 'h0C);
    step(0, 0, 16'h3004, 1, 0, 8'h00);
    rd_reg("R4 rewritable", 'h00);
    step(1, 1, 16'h3004, 1, 0, 8'hAA);           // R5 both resets
    rd_reg("R5 por priority", 'h0C);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 11);
      step(0, 1, 16'h0, 0, 0, 8'h00);
      step(0, 0, 16'h3004, 1, 0, v);
      step(0, 0, 16'h3004, 1, 1, ~v);
      step(0, 0, 16'h2004, 1, 1, 8'h00);
    end
    step(1, 0, 16'h0, 0, 0, 8'h00);
    rd_reg("R1 final", 'h0C);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule